// File: doc/BRIEF.md
# Four-Bank Interleaved Word Memory

This block is a word-addressed memory split across four banks. The two low bits of a word address choose the bank, and the remaining bits choose the row inside that bank. Consecutive addresses therefore fall in different banks and can be served together. A requester reaches the banks through four independent request ports. Each port carries its own address, write flag and write data. Requests that target different banks are accepted in the same cycle and run side by side.

A separate burst channel takes a single row index. It reads or writes the four consecutive words of that row in one operation, one word per bank, over a data path four words wide.

Each bank models a synchronous RAM with a fixed latency. A bank stays busy while an access is in flight. A request that finds its bank busy, or that loses arbitration for its bank, is held with its ready signal low until it can be taken. Read results come back on a lane per bank. Each lane carries the number of the port that issued the read and a flag that marks burst results.

Top module: `ilv_mem`

## Requirements
- R1: Word address A lives in bank A mod 4 at row A >> 2. Its read result appears on response lane A mod 4. A burst on row r covers words 4r, 4r+1, 4r+2 and 4r+3, and lane b carries word 4r+b.
- R2: A port read accepted on clock edge n gives `rsp_vld_o[b]` high on lane b in the cycle after edge n+2, and for that cycle only. The lane carries the word last written at that address, `rsp_bst_o[b]` low, and the issuing port number on the lane's 2-bit field of `rsp_port_o`.
- R3: A write accepted on a port stores its data at that address and produces no response.
- R4: Port requests that target four distinct banks are all accepted in the same cycle.
- R5: Ready is never high on a port whose valid is low. When several valid ports target the same free bank, only the lowest-numbered one is accepted.
- R6: A bank that accepts an access on edge n accepts nothing on edges n+1 and n+2. It can accept again on edge n+3, the same cycle in which its read result is visible.
- R7: A burst read accepted on edge n returns all four words together in the cycle after edge n+2. Every lane in that cycle has `rsp_bst_o` high and a port field of 0.
- R8: A burst write stores all four words of the row in a single accepted operation.
- R9: `bst_rdy_o` is high exactly when all four banks are free. While `bst_vld_i` is high, no port request is accepted.
- R10: After reset, no response is valid, `bst_rdy_o` is high, and no port is ready while its valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_vld_i | input | 4 | Per-port request valid |
| req_we_i | input | 4 | Per-port write flag (1 = write) |
| req_addr_i | input | 4*ADDR_W | Per-port word address, port p at bits [p*ADDR_W +: ADDR_W] |
| req_wdata_i | input | 4*DATA_W | Per-port write data |
| req_rdy_o | output | 4 | Per-port accept in this cycle |
| bst_vld_i | input | 1 | Burst request valid |
| bst_we_i | input | 1 | Burst write flag |
| bst_row_i | input | ADDR_W-2 | Burst row index |
| bst_wdata_i | input | 4*DATA_W | Burst write words, bank b at bits [b*DATA_W +: DATA_W] |
| bst_rdy_o | output | 1 | Burst accept in this cycle |
| rsp_vld_o | output | 4 | Read result valid, one lane per bank |
| rsp_bst_o | output | 4 | Lane result belongs to a burst |
| rsp_port_o | output | 4*2 | Issuing port of each lane's result |
| rsp_data_o | output | 4*DATA_W | Read data per lane |

## Verification
The assertions assume that the requester keeps valid, address, write flag and data stable from just after one rising edge until the next. They also assume that the latency parameter is at least 2, so that the one-access-per-bank-per-window rule can be observed. The bench changes every input only at the falling edge and samples ready half a cycle before the accepting edge. It never changes a request while that request is waiting. Reads are issued only to addresses the bench has written earlier, so each expected word is known before it is read.

// File: rtl/ilv_mem_pkg.sv
package ilv_mem_pkg;
  localparam int unsigned NB   = 4;  // banks, also number of request ports
  localparam int unsigned NB_W = 2;  // bank select bits
endpackage

// File: rtl/ilv_arb.sv
module ilv_arb #(
  parameter int unsigned N     = 4,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  input  logic             en_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic hit;

  // fixed priority: lowest index wins
  always_comb begin
    idx_o = '0;
    hit   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        hit   = 1'b1;
      end
    end
  end

  always_comb begin
    gnt_o = '0;
    if (en_i && hit) gnt_o[idx_o] = 1'b1;
  end

  assign any_o = en_i && hit;
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LAT    = 3,
  parameter int unsigned SRC_W  = 2,
  localparam int unsigned DEPTH = 1 << ROW_W,
  localparam int unsigned CNT_W = $clog2(LAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic              bst_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              free_o,
  output logic              rsp_vld_o,
  output logic              rsp_bst_o,
  output logic [SRC_W-1:0]  rsp_src_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rd_q, bst_q;
  logic [SRC_W-1:0]  src_q;

  always_ff @(posedge clk_i) begin
    if (acc_i && we_i) mem_q[row_i] <= wdata_i;
    if (acc_i && !we_i) data_q <= mem_q[row_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rd_q  <= 1'b0;
      bst_q <= 1'b0;
      src_q <= '0;
    end else if (acc_i) begin
      cnt_q <= CNT_W'(LAT);
      rd_q  <= !we_i;
      bst_q <= bst_i;
      src_q <= src_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // free in the last busy cycle so back-to-back accesses overlap the result
  assign free_o     = cnt_q <= CNT_W'(1);
  assign rsp_vld_o  = (cnt_q == CNT_W'(1)) && rd_q;
  assign rsp_bst_o  = bst_q;
  assign rsp_src_o  = src_q;
  assign rsp_data_o = data_q;
endmodule

// File: rtl/ilv_mem.sv
module ilv_mem
  import ilv_mem_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LAT    = 3,
  localparam int unsigned NP    = NB,
  localparam int unsigned ROW_W = ADDR_W - NB_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NP-1:0]        req_vld_i,
  input  logic [NP-1:0]        req_we_i,
  input  logic [NP*ADDR_W-1:0] req_addr_i,
  input  logic [NP*DATA_W-1:0] req_wdata_i,
  output logic [NP-1:0]        req_rdy_o,
  input  logic                 bst_vld_i,
  input  logic                 bst_we_i,
  input  logic [ROW_W-1:0]     bst_row_i,
  input  logic [NB*DATA_W-1:0] bst_wdata_i,
  output logic                 bst_rdy_o,
  output logic [NB-1:0]        rsp_vld_o,
  output logic [NB-1:0]        rsp_bst_o,
  output logic [NB*NB_W-1:0]   rsp_port_o,
  output logic [NB*DATA_W-1:0] rsp_data_o
);
  logic [NB-1:0]         free;
  logic [NB-1:0][NP-1:0] gnt_mat;
  logic                  bst_acc;

  assign bst_rdy_o = &free;
  assign bst_acc   = bst_vld_i && bst_rdy_o;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [NP-1:0]     hit, gnt;
    logic [NB_W-1:0]   idx;
    logic              any;
    logic              acc, we;
    logic [ROW_W-1:0]  row;
    logic [DATA_W-1:0] wdata;
    logic [NB_W-1:0]   src;

    // a pending burst blocks all port traffic so banks drain for it
    always_comb begin
      for (int p = 0; p < NP; p++) begin
        hit[p] = req_vld_i[p] && !bst_vld_i &&
                 (req_addr_i[p*ADDR_W +: NB_W] == NB_W'(b));
      end
    end

    ilv_arb #(.N(NP)) u_arb (
      .req_i (hit),
      .en_i  (free[b]),
      .gnt_o (gnt),
      .idx_o (idx),
      .any_o (any)
    );

    assign gnt_mat[b] = gnt;
    assign acc   = bst_acc || any;
    assign we    = bst_acc ? bst_we_i : req_we_i[idx];
    assign row   = bst_acc ? bst_row_i : req_addr_i[idx*ADDR_W + NB_W +: ROW_W];
    assign wdata = bst_acc ? bst_wdata_i[b*DATA_W +: DATA_W]
                           : req_wdata_i[idx*DATA_W +: DATA_W];
    assign src   = bst_acc ? '0 : idx;

    ilv_bank #(
      .ROW_W (ROW_W),
      .DATA_W(DATA_W),
      .LAT   (LAT),
      .SRC_W (NB_W)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .acc_i     (acc),
      .we_i      (we),
      .bst_i     (bst_acc),
      .src_i     (src),
      .row_i     (row),
      .wdata_i   (wdata),
      .free_o    (free[b]),
      .rsp_vld_o (rsp_vld_o[b]),
      .rsp_bst_o (rsp_bst_o[b]),
      .rsp_src_o (rsp_port_o[b*NB_W +: NB_W]),
      .rsp_data_o(rsp_data_o[b*DATA_W +: DATA_W])
    );
  end

  always_comb begin
    req_rdy_o = '0;
    for (int b = 0; b < NB; b++) req_rdy_o |= gnt_mat[b];
  end
endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk
  import ilv_mem_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LAT    = 3,
  localparam int unsigned NP    = NB,
  localparam int unsigned SNC_W = $clog2(LAT + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NP-1:0]        req_vld_i,
  input logic [NP*ADDR_W-1:0] req_addr_i,
  input logic [NP-1:0]        req_rdy_o,
  input logic                 bst_vld_i,
  input logic                 bst_rdy_o,
  input logic [NB-1:0]        rsp_vld_o
);
  logic [NB-1:0][NP-1:0] rdy_to;
  logic [NB-1:0]         acc_bank;
  logic [NP-1:0]         lower_vld;

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      for (int p = 0; p < NP; p++)
        rdy_to[b][p] = req_rdy_o[p] && (req_addr_i[p*ADDR_W +: NB_W] == NB_W'(b));
      acc_bank[b] = (|rdy_to[b]) || (bst_vld_i && bst_rdy_o);
    end
    for (int p = 0; p < NP; p++) begin
      lower_vld[p] = 1'b0;
      for (int q = 0; q < p; q++)
        if (req_vld_i[q] && req_addr_i[q*ADDR_W +: NB_W] == req_addr_i[p*ADDR_W +: NB_W])
          lower_vld[p] = 1'b1;
    end
  end

  assert_burst_blocks_ports_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bst_vld_i |-> (req_rdy_o == '0));

  for (genvar p = 0; p < NP; p++) begin : g_port
    assert_rdy_needs_vld_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_rdy_o[p] |-> req_vld_i[p]);
    assert_low_port_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_rdy_o[p] |-> !lower_vld[p]);
  end

  for (genvar b = 0; b < NB; b++) begin : g_bk
    logic [SNC_W-1:0] since_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     since_q <= SNC_W'(LAT);
      else if (acc_bank[b])            since_q <= '0;
      else if (since_q < SNC_W'(LAT))  since_q <= since_q + 1'b1;
    end

    assert_single_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(rdy_to[b]) <= 1);
    assert_busy_after_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_bank[b] |=> !acc_bank[b]);
    assert_rsp_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_vld_o[b] |-> (since_q == SNC_W'(LAT - 1)));
  end
endmodule

bind ilv_mem ilv_mem_chk #(.ADDR_W(ADDR_W), .LAT(LAT)) u_chk (.*);

// File: tb/ilv_mem_tb.sv
module ilv_mem_tb;
  import ilv_mem_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int RW = AW - NB_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NB-1:0]     req_vld = '0, req_we = '0, req_rdy;
  logic [NB*AW-1:0]  req_addr = '0;
  logic [NB*DW-1:0]  req_wdata = '0;
  logic              bst_vld = 1'b0, bst_we = 1'b0, bst_rdy;
  logic [RW-1:0]     bst_row = '0;
  logic [NB*DW-1:0]  bst_wdata = '0;
  logic [NB-1:0]     rsp_vld, rsp_bst;
  logic [NB*NB_W-1:0] rsp_port;
  logic [NB*DW-1:0]  rsp_data;

  ilv_mem #(.ADDR_W(AW), .DATA_W(DW), .LAT(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_vld_i(req_vld), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_rdy_o(req_rdy),
    .bst_vld_i(bst_vld), .bst_we_i(bst_we), .bst_row_i(bst_row),
    .bst_wdata_i(bst_wdata), .bst_rdy_o(bst_rdy),
    .rsp_vld_o(rsp_vld), .rsp_bst_o(rsp_bst), .rsp_port_o(rsp_port),
    .rsp_data_o(rsp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          lane;
    int          port;
    bit          bst;
    logic [DW-1:0] data;
    int          due;
  } exp_t;

  exp_t          sb_q[$];
  logic [DW-1:0] model [1 << AW];
  int            cyc = 0;
  int            n_chk = 0;
  int            n_bad = 0;
  logic [NB-1:0] rdy_s;
  logic          brdy_s;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic set_port(int p, bit we, int addr, int wd);
    req_vld[p] = 1'b1;
    req_we[p]  = we;
    req_addr[p*AW +: AW]  = AW'(addr);
    req_wdata[p*DW +: DW] = DW'(wd);
  endtask

  task automatic clear_all();
    req_vld = '0;
    req_we  = '0;
    bst_vld = 1'b0;
    bst_we  = 1'b0;
  endtask

  // driver: inputs already set after a falling edge; sample ready, record, move on
  task automatic tick();
    int a;
    #1;
    rdy_s  = req_rdy;
    brdy_s = bst_rdy;
    for (int p = 0; p < NB; p++) begin
      if (req_vld[p] && rdy_s[p]) begin
        a = int'(req_addr[p*AW +: AW]);
        if (req_we[p]) model[a] = req_wdata[p*DW +: DW];
        else sb_q.push_back('{lane: a % 4, port: p, bst: 1'b0, data: model[a], due: cyc + 3});
      end
    end
    if (bst_vld && brdy_s) begin
      for (int b = 0; b < NB; b++) begin
        a = int'(bst_row) * 4 + b;
        if (bst_we) model[a] = bst_wdata[b*DW +: DW];
        else sb_q.push_back('{lane: b, port: 0, bst: 1'b1, data: model[a], due: cyc + 3});
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    clear_all();
    for (int i = 0; i < n; i++) tick();
  endtask

  // monitor: outputs change only on rising edges
  always @(negedge clk) begin
    if (rst_n) begin
      for (int b = 0; b < NB; b++) begin
        if (rsp_vld[b]) begin
          int hit_i;
          hit_i = -1;
          for (int i = 0; i < sb_q.size(); i++)
            if (hit_i < 0 && sb_q[i].lane == b) hit_i = i;
          check(hit_i >= 0, "R3", "response with nothing pending, lane", b, -1);
          if (hit_i >= 0) begin
            exp_t e;
            e = sb_q[hit_i];
            sb_q.delete(hit_i);
            check(e.due == cyc, e.bst ? "R7" : "R2", "response cycle", cyc, e.due);
            check(rsp_data[b*DW +: DW] == e.data, e.bst ? "R7" : "R1",
                  "lane data", int'(rsp_data[b*DW +: DW]), int'(e.data));
            check(rsp_bst[b] == e.bst, e.bst ? "R7" : "R2", "burst flag",
                  int'(rsp_bst[b]), int'(e.bst));
            check(int'(rsp_port[b*NB_W +: NB_W]) == e.port, e.bst ? "R7" : "R2",
                  "port tag", int'(rsp_port[b*NB_W +: NB_W]), e.port);
          end
        end
      end
      for (int i = sb_q.size() - 1; i >= 0; i--) begin
        if (sb_q[i].due < cyc) begin
          check(1'b0, sb_q[i].bst ? "R7" : "R2", "missing response, lane",
                -1, sb_q[i].lane);
          sb_q.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    #1;
    check(rsp_vld == '0, "R10", "rsp_vld after reset", int'(rsp_vld), 0);
    check(bst_rdy == 1'b1, "R10", "bst_rdy after reset", int'(bst_rdy), 1);
    check(req_rdy == '0, "R10", "req_rdy with no valid", int'(req_rdy), 0);
    @(negedge clk);

    // R8: burst writes of rows 0..3 and row 63
    for (int r = 0; r < 5; r++) begin
      clear_all();
      bst_vld = 1'b1; bst_we = 1'b1;
      bst_row = RW'((r == 4) ? 63 : r);
      for (int b = 0; b < NB; b++) bst_wdata[b*DW +: DW] = DW'(16'h1000 + r*16 + b);
      tick();
      check(brdy_s == 1'b1, "R8", "burst write accepted", int'(brdy_s), 1);
      idle(2);
    end

    // R8 readback through ports, R4 all four distinct banks in one cycle
    clear_all();
    for (int p = 0; p < NB; p++) set_port(p, 1'b0, 8 + ((p + 1) % 4), 0);
    tick();
    check(rdy_s == 4'hf, "R4", "distinct-bank reads accepted", int'(rdy_s), 'hf);
    idle(3);

    // R7: burst read of row 2
    clear_all();
    bst_vld = 1'b1; bst_row = RW'(2);
    tick();
    check(brdy_s == 1'b1, "R7", "burst read accepted", int'(brdy_s), 1);
    idle(3);

    // R3 and R1: port writes to high addresses, then burst read of row 63
    clear_all();
    set_port(0, 1'b1, 8'hfd, 16'hbeef);
    set_port(2, 1'b1, 8'hfe, 16'h5a5a);
    set_port(3, 1'b1, 8'h13, 16'h7777);
    tick();
    check(rdy_s == 4'b1101, "R3", "writes accepted", int'(rdy_s), 'b1101);
    idle(3);
    clear_all();
    bst_vld = 1'b1; bst_row = RW'(63);
    tick();
    idle(3);
    clear_all();
    set_port(1, 1'b0, 8'h13, 0);
    tick();
    check(rdy_s == 4'b0010, "R1", "read of address 0x13 accepted", int'(rdy_s), 'b0010);
    idle(3);

    // R5, R6: ports 1 and 3 hit bank 2; port 0 hits bank 1 alongside
    clear_all();
    set_port(1, 1'b0, 6, 0);
    set_port(3, 1'b0, 10, 0);
    set_port(0, 1'b0, 9, 0);
    tick();
    check(rdy_s == 4'b0011, "R5", "lower port wins bank 2", int'(rdy_s), 'b0011);
    req_vld[0] = 1'b0;
    req_vld[1] = 1'b0;
    tick();
    check(rdy_s == 4'b0000, "R6", "bank busy one cycle on", int'(rdy_s), 0);
    tick();
    check(rdy_s == 4'b0000, "R6", "bank busy two cycles on", int'(rdy_s), 0);
    tick();
    check(rdy_s == 4'b1000, "R6", "bank free in result cycle", int'(rdy_s), 'b1000);
    idle(3);

    // R9: burst waits for all banks, ports blocked meanwhile
    clear_all();
    set_port(0, 1'b0, 0, 0);
    tick();
    check(rdy_s == 4'b0001, "R9", "port read before burst", int'(rdy_s), 1);
    clear_all();
    bst_vld = 1'b1; bst_row = RW'(1);
    set_port(2, 1'b0, 1, 0);
    tick();
    check(brdy_s == 1'b0 && rdy_s == '0, "R9", "burst held, port blocked",
          int'({brdy_s, rdy_s}), 0);
    tick();
    check(brdy_s == 1'b0 && rdy_s == '0, "R9", "burst still held",
          int'({brdy_s, rdy_s}), 0);
    tick();
    check(brdy_s == 1'b1 && rdy_s == '0, "R9", "burst taken once banks free",
          int'({brdy_s, rdy_s}), 'h10);
    idle(6);

    check(sb_q.size() == 0, "R2", "responses left pending", sb_q.size(), 0);
    finish_run();
  end
endmodule